// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is the slave side of a 128-byte serial memory that sits on an open-drain two-wire bus. A fast system clock oversamples the clock line and the data line through two-flop synchronizers. The block finds bus framing events, collects bytes MSB first and acknowledges each byte it accepts. It answers reads by shifting stored bytes back out. The data line is driven only as an open-drain enable: `sda_oe` high pulls the line low, and low releases it.

A write transfer has a device-select byte with the read/write bit clear, a word address, and any number of data bytes. The data bytes go into an eight-entry circular buffer. Each entry holds the byte and its destination address, so a long write keeps only its final eight bytes, and each new byte displaces the oldest one. The STOP that closes a write with at least one data byte starts a programming window that lasts `PROG_CYCLES` system clocks. During the first clocks of that window the buffered entries are copied into the array. For the whole window `busy` is high and the slave leaves the bus alone. A read returns bytes from the internal address pointer, which advances and wraps after each byte. The read continues until the master answers a byte with no acknowledge.

The controller has these states. IDLE waits for START. DEVSEL collects the select byte. On a match it goes to DEV_ACK, and on a miss or while busy it goes to SKIP. DEV_ACK goes to RDATA when bit 0 is 1, and to ADDR when bit 0 is 0. ADDR goes to ADDR_ACK, and then to WDATA. WDATA and WDATA_ACK alternate for each data byte. RDATA goes to RACK. RACK goes back to RDATA when the master acknowledges, and to SKIP when it does not. Except for the two framing events, state changes take place on falling SCL. START leads from any state to DEVSEL, and STOP leads from any state to IDLE.

Top module: `ee2w_slave`

## Requirements
- R1: After reset, `sda_oe` and `busy` are both low.
- R2: A falling data line while the clock line is high (START) restarts the collection of a device-select byte from any state. This includes a repeated START in the middle of a transfer. A rising data line while the clock line is high (STOP) returns the block to idle.
- R3: The device-select byte carries the address 1010000 in bits 7:1 and the direction in bit 0 (1 = read, 0 = write). A select byte that does not match gets no acknowledge, and every later byte is ignored without acknowledge until the next START.
- R4: For each accepted byte (select, word address, write data), the slave drives `sda_oe` high through the ninth clock pulse. The line is therefore low for the whole high phase of that pulse, and the slave releases it after that pulse falls.
- R5: The word address uses bits 6:0 of the address byte, and bit 7 is ignored. Write data goes to consecutive addresses that wrap from 127 to 0.
- R6: When a write carries more than eight data bytes, only the last eight are stored. Each of them goes to the address the pointer held when it arrived. Earlier bytes of that write do not change the array.
- R7: A STOP that ends a write with at least one data byte raises `busy` for exactly `PROG_CYCLES` system clocks, and the data is readable afterwards. A write with an address and no data leaves `busy` low.
- R8: While `busy` is high the slave acknowledges no byte and never drives the data line.
- R9: A read sends bytes MSB first, and a 0 bit pulls the line low. Each acknowledged byte is followed by the next address, with a wrap from 127 to 0. A read that starts directly with a select byte continues from the current pointer.
- R10: When the master leaves a read byte without acknowledge, the slave releases the data line and keeps it released until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| busy | output | 1 | High during the internal programming window |

## Verification
The bench builds the block with `PROG_CYCLES` set to 600, with eight buffer entries and with the default select address. This window is short enough that the length of `busy` can be counted exactly for every write. It is also long enough that a complete select byte with its ninth pulse fits inside the window, so the silence while busy can be observed on the bus. With eight buffer entries, a ten-byte write is enough to push the two oldest bytes out. The bench also drives writes and reads that cross the 127 to 0 boundary.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
    localparam int EE_AW = 7;
    localparam int EE_DW = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEVSEL,
        S_DEV_ACK,
        S_ADDR,
        S_ADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK,
        S_SKIP
    } ee_state_t;

    typedef struct packed {
        logic [EE_AW-1:0] addr;
        logic [EE_DW-1:0] data;
    } wr_entry_t;
endpackage

// File: rtl/ee2w_busio.sv
module ee2w_busio #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] line_in;
    logic [1:0] line_s;
    logic       scl_q;
    logic       sda_q;

    assign line_in = {scl_i, sda_i};

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_sync
            logic [STAGES-1:0] pipe;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[STAGES-2:0], line_in[g]};
            end
            assign line_s[g] = pipe[STAGES-1];
        end
    endgenerate

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ee2w_wbuf.sv
module ee2w_wbuf
    import ee2w_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  wr_entry_t        push_ent,
    input  logic [IDX_W-1:0] rd_idx,
    output wr_entry_t        rd_ent,
    output logic [CNT_W-1:0] cnt
);
    wr_entry_t        slots [DEPTH];
    logic [IDX_W-1:0] wptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            cnt  <= '0;
        end else if (clr) begin
            wptr <= '0;
            cnt  <= '0;
        end else if (push) begin
            wptr <= wptr + 1'b1;
            if (cnt != CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr) slots[wptr] <= push_ent;
    end

    assign rd_ent = slots[rd_idx];

    AST_BUF_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && cnt == CNT_W'(DEPTH)) |=> (cnt == CNT_W'(DEPTH))) else $error("full buffer count moved"); // R6
    AST_BUF_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && cnt < CNT_W'(DEPTH)) |=> (cnt == $past(cnt) + 1'b1)) else $error("buffer count did not grow"); // R6
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
    import ee2w_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1010000,
    parameter int         PROG_CYCLES = 4000,
    parameter int         BUF_DEPTH   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic busy
);
    localparam int MEM_WORDS = 1 << EE_AW;
    localparam int IDX_W     = $clog2(BUF_DEPTH);
    localparam int CNT_W     = IDX_W + 1;
    localparam int PCNT_W    = $clog2(PROG_CYCLES + 1);
    localparam int BITS_W    = $clog2(EE_DW + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    ee_state_t         state, nxt;
    logic [BITS_W-1:0] bit_cnt;
    logic [EE_DW-1:0]  rx, tx;
    logic              rw_q, m_ack, wr_pend;
    logic [EE_AW-1:0]  ptr;
    logic [PCNT_W-1:0] pcnt;
    logic              byte_done, dev_hit, buf_clr, buf_push, commit_en;
    wr_entry_t         push_ent, commit_ent;
    logic [CNT_W-1:0]  buf_cnt;
    logic [EE_DW-1:0]  mem [MEM_WORDS];

    ee2w_busio #(.STAGES(2)) u_busio (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    assign byte_done = (bit_cnt == BITS_W'(EE_DW));
    assign dev_hit   = (rx[EE_DW-1:1] == DEV_ADDR) && !busy;
    assign buf_clr   = (state == S_DEVSEL) && (nxt == S_DEV_ACK) && !rx[0];
    assign buf_push  = (state == S_WDATA) && (nxt == S_WDATA_ACK);
    assign push_ent  = '{addr: ptr, data: rx};
    assign commit_en = busy && (pcnt < PCNT_W'(buf_cnt));

    ee2w_wbuf #(.DEPTH(BUF_DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .push(buf_push),
        .push_ent(push_ent), .rd_idx(pcnt[IDX_W-1:0]), .rd_ent(commit_ent), .cnt(buf_cnt)
    );

    // next-state selection
    always_comb begin
        nxt = state;
        if (start_ev) begin
            nxt = S_DEVSEL;
        end else if (stop_ev) begin
            nxt = S_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                S_DEVSEL:    if (byte_done) nxt = dev_hit ? S_DEV_ACK : S_SKIP;
                S_DEV_ACK:   nxt = rw_q ? S_RDATA : S_ADDR;
                S_ADDR:      if (byte_done) nxt = S_ADDR_ACK;
                S_ADDR_ACK:  nxt = S_WDATA;
                S_WDATA:     if (byte_done) nxt = S_WDATA_ACK;
                S_WDATA_ACK: nxt = S_WDATA;
                S_RDATA:     if (byte_done) nxt = S_RACK;
                S_RACK:      nxt = m_ack ? S_RDATA : S_SKIP;
                default:     nxt = state;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            bit_cnt <= '0;
            rx      <= '0;
            tx      <= '0;
            rw_q    <= 1'b0;
            m_ack   <= 1'b0;
            ptr     <= '0;
            wr_pend <= 1'b0;
            busy    <= 1'b0;
            pcnt    <= '0;
        end else begin
            state <= nxt;
            if (nxt != state || start_ev)             bit_cnt <= '0;
            else if (scl_rise && !byte_done)          bit_cnt <= bit_cnt + 1'b1;
            if (scl_rise)                             rx <= {rx[EE_DW-2:0], sda_s};
            if (state == S_RACK && scl_rise)          m_ack <= ~sda_s;
            if (state == S_DEVSEL && nxt == S_DEV_ACK) rw_q <= rx[0];
            if (state == S_ADDR && nxt == S_ADDR_ACK)  ptr <= rx[EE_AW-1:0];
            if (nxt == S_RDATA && state != S_RDATA) begin
                tx  <= mem[ptr];
                ptr <= ptr + 1'b1;
            end else if (state == S_RDATA && scl_fall && !byte_done) begin
                tx <= {tx[EE_DW-2:0], 1'b0};
            end
            if (buf_push) begin
                ptr     <= ptr + 1'b1;
                wr_pend <= 1'b1;
            end
            if (start_ev) wr_pend <= 1'b0;
            if (stop_ev && wr_pend) begin
                wr_pend <= 1'b0;
                busy    <= 1'b1;
                pcnt    <= '0;
            end else if (busy) begin
                pcnt <= pcnt + 1'b1;
                if (pcnt == PCNT_W'(PROG_CYCLES - 1)) busy <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (commit_en) mem[commit_ent.addr] <= commit_ent.data;
    end

    // open-drain output
    always_comb begin
        unique case (state)
            S_DEV_ACK, S_ADDR_ACK, S_WDATA_ACK: sda_oe = 1'b1;
            S_RDATA:                            sda_oe = ~tx[EE_DW-1];
            default:                            sda_oe = 1'b0;
        endcase
    end

    AST_SILENT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe) else $error("line driven while busy"); // R8
    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_ev)) else $error("busy rose without stop"); // R7
    AST_OE_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !start_ev && !stop_ev) |-> $stable(sda_oe)) else $error("drive changed while clock high"); // R4
endmodule

// File: tb/ee2w_slave_tb.sv
module ee2w_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 600;
    localparam int HALF       = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, busy, sda_line;
    int   n_chk = 0;
    int   n_bad = 0;
    int   busy_cycles = 0;
    bit   done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    ee2w_slave #(.DEV_ADDR(7'b1010000), .PROG_CYCLES(PROG), .BUF_DEPTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (busy) busy_cycles++;

    // {word address, data}
    localparam logic [15:0] VEC [6] = '{16'h003C, 16'h7FA5, 16'h855A, 16'h40FF, 16'h1200, 16'h3381};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_xfer(input bit v, output bit smp);
        wt(HALF); sda_m = v; wt(HALF);
        scl_m = 1'b1; wt(HALF); smp = sda_line; wt(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wt(HALF); scl_m = 1'b1; wt(HALF); sda_m = 1'b0; wt(HALF); scl_m = 1'b0;
    endtask

    task automatic bus_stop;
        wt(HALF); sda_m = 1'b0; wt(HALF); scl_m = 1'b1; wt(HALF); sda_m = 1'b1; wt(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
        bit_xfer(1'b1, s);
        acked = !s;
    endtask

    task automatic read_byte(input bit ack, output logic [7:0] d);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            d[i] = s;
        end
        bit_xfer(!ack, s);
    endtask

    task automatic wait_idle;
        while (busy) wt(1);
        wt(4);
    endtask

    task automatic write_seq(input logic [7:0] a, input int n, input logic [7:0] v0, input bit wait_done);
        bit ak;
        busy_cycles = 0;
        bus_start;
        send_byte(8'hA0, ak); chk(ak, "R4 select ack", ak, 1);
        send_byte(a, ak);     chk(ak, "R4 address ack", ak, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(v0 + 8'(i), ak); chk(ak, "R4 data ack", ak, 1);
        end
        bus_stop;
        chk(busy == 1'b1, "R7 busy after stop", busy, 1);
        if (wait_done) begin
            wait_idle;
            chk(busy_cycles == PROG, "R7 busy length", busy_cycles, PROG);
        end
    endtask

    task automatic random_read(input logic [6:0] a, input int n, input logic [7:0] exp [16], input string req);
        bit ak;
        logic [7:0] d;
        bus_start;
        send_byte(8'hA0, ak);      chk(ak, "R2 select ack", ak, 1);
        send_byte({1'b0, a}, ak);  chk(ak, "R2 address ack", ak, 1);
        bus_start;
        send_byte(8'hA1, ak);      chk(ak, "R2 repeated-start select ack", ak, 1);
        for (int i = 0; i < n; i++) begin
            read_byte(i < n - 1, d);
            chk(d === exp[i], req, d, exp[i]);
        end
        bus_stop;
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report;
            $finish;
        end
    end

    initial begin
        logic [7:0] e [16];
        logic [7:0] d;
        bit ak, s;
        wt(5);
        rst_n = 1'b1;
        wt(5);
        chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);

        // table: single-byte write, then random read through a repeated START (R2, R5, R9)
        foreach (VEC[k]) begin
            write_seq(VEC[k][15:8], 1, VEC[k][7:0], 1'b1);
            e[0] = VEC[k][7:0];
            random_read(VEC[k][14:8], 1, e, "R5 R9 readback");
        end

        // R3: foreign select byte is ignored
        bus_start;
        send_byte(8'hA2, ak); chk(!ak, "R3 foreign select no ack", ak, 0);
        send_byte(8'h00, ak); chk(!ak, "R3 later byte no ack", ak, 0);
        bus_stop;
        chk(busy == 1'b0, "R3 no programming", busy, 0);

        // R5/R9: write and read across 127 -> 0
        write_seq(8'd126, 3, 8'h70, 1'b1);
        e[0] = 8'h70; e[1] = 8'h71; e[2] = 8'h72;
        random_read(7'd126, 3, e, "R5 R9 wrap");

        // R6: ten bytes, only the last eight kept
        write_seq(8'd40, 2, 8'hEE, 1'b1);
        write_seq(8'd40, 10, 8'h10, 1'b1);
        e[0] = 8'hEE; e[1] = 8'hEF;
        for (int i = 2; i < 10; i++) e[i] = 8'h10 + 8'(i);
        random_read(7'd40, 10, e, "R6 last eight kept");

        // R8: select during programming is not acknowledged
        write_seq(8'd10, 1, 8'hC3, 1'b0);
        bus_start;
        send_byte(8'hA0, ak);
        chk(!ak, "R8 no ack while busy", ak, 0);
        chk(busy == 1'b1, "R8 still busy", busy, 1);
        bus_stop;
        wait_idle;
        e[0] = 8'hC3;
        random_read(7'd10, 1, e, "R8 write committed");

        // R7: address-only write; R9 current-address read; R10 release after nack
        bus_start;
        send_byte(8'hA0, ak);  chk(ak, "R4 select ack", ak, 1);
        send_byte(8'h7F, ak);  chk(ak, "R4 address ack", ak, 1);
        bus_stop;
        chk(busy == 1'b0, "R7 no data no busy", busy, 0);
        bus_start;
        send_byte(8'hA1, ak);  chk(ak, "R9 current read ack", ak, 1);
        read_byte(1'b1, d);    chk(d === 8'h71, "R9 current address", d, 8'h71);
        read_byte(1'b0, d);    chk(d === 8'h72, "R9 wrap to 0", d, 8'h72);
        wt(HALF);
        chk(sda_oe == 1'b0, "R10 released after nack", sda_oe, 0);
        bit_xfer(1'b1, s);
        chk(s == 1'b1, "R10 line high after nack", s, 1);
        bus_stop;

        done = 1'b1;
        report;
        $finish;
    end
endmodule